// File: doc/BRIEF.md
# Square-Array One-Bit Memory Device

This block is a small synchronous model of a memory chip. Its bits are kept in an internal square array of rows and columns. Externally it looks like a tall, narrow device with one data bit per location. The high part of the location address drives a one-hot word-line decoder that picks a row. The low part steers a single bit: on reads a column multiplexer selects it from the chosen row, and on writes a column demultiplexer points the new bit at one cell.

Three controls govern every access: chip select, output enable and write enable. When chip select is low, the device does nothing. A read drives the stored bit out one clock later, together with a drive-enable flag that stands in for a tristate pin. A write behaves like a strobe. The address and data seen in the last cycle of the strobe are stored when the strobe ends, at the edge where write enable (or chip select) is first sampled low. A read of the location being committed in that same cycle returns the new bit.

Top module: `sqarr_bitmem`

## Requirements
- R1: After reset, dout_oe and dout are 0 and every one of the 16 locations reads back as 0.
- R2: If chip_sel=1, out_en=1 and wr_en=0 are sampled at a clock edge, then after the next edge dout_oe=1 and dout holds the bit stored at addr. The locations are addr 0 to 15: addr[3:2] selects the row and addr[1:0] selects the column.
- R3: In any cycle whose previous edge did not sample a read as defined in R2, dout_oe is 0 and dout is 0.
- R4: While chip_sel=0, the inputs out_en, wr_en, addr and din have no effect. No output is enabled and no location changes.
- R5: A write strobe is a run of edges that sample chip_sel=1 and wr_en=1. At the first edge that samples the strobe inactive, the din value from the strobe's last cycle is stored at the addr from that same cycle. Values driven in earlier cycles of the strobe are not stored.
- R6: If wr_en and out_en are both 1 with chip_sel=1, the write takes priority and dout_oe stays 0 in the following cycle.
- R7: A write changes only the addressed cell. The other three cells of that row, and all other rows, keep their values.
- R8: A read sampled at the same edge as a write commit returns the committed bit when the addresses match, and the stored bit otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel | input | 1 | Chip select, active high |
| out_en | input | 1 | Output enable (read request), active high |
| wr_en | input | 1 | Write enable strobe, active high |
| addr | input | 4 | Location address: row in the high bits, column in the low bits |
| din | input | 1 | Data bit to write |
| dout | output | 1 | Read data bit, 0 when not driven |
| dout_oe | output | 1 | Drive enable for dout (models the tristate) |

## Verification
A write commit and a read can fall in the same cycle. The commit happens at the edge where the strobe ends, and a read issued in the very next cycle is sampled at that same edge. The bench provokes this by ending a strobe and reading the same location, and also a different location, immediately after. The behavioural reference model applies the commit before it computes the expected read bit, so a stale bit from the array is reported against the forwarded one. Collisions between write enable and output enable are provoked the same way, and the bench checks that the output stays disabled.

// File: rtl/sqm_pkg.sv
package sqm_pkg;

  // Classification of one sampled cycle at the device pins.
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } sqm_acc_e;

endpackage

// File: rtl/sqm_onehot_decoder.sv
// Binary index to one-hot select lines (word lines or column strobes).
module sqm_onehot_decoder #(
  parameter int SEL_BITS = 2
) (
  input  logic [SEL_BITS-1:0]        sel_idx,
  output logic [(1<<SEL_BITS)-1:0]   sel_lines
);

  localparam int LINES = 1 << SEL_BITS;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    assign sel_lines[l] = (sel_idx == SEL_BITS'(l));
  end

endmodule

// File: rtl/sqm_write_ctrl.sv
// Tracks the write strobe, captures address/data each active cycle and
// issues a one-cycle commit when the strobe ends.
module sqm_write_ctrl #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic              commit_bit
);

  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              bit_q, bit_d;

  always_comb begin
    pend_d = strobe;
    addr_d = addr_q;
    bit_d  = bit_q;
    if (strobe) begin
      addr_d = addr;
      bit_d  = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      bit_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      addr_q <= addr_d;
      bit_q  <= bit_d;
    end
  end

  assign commit      = pend_q & ~strobe;
  assign commit_addr = addr_q;
  assign commit_bit  = bit_q;

endmodule

// File: rtl/sqm_cell_array.sv
// Square storage array: per-cell write enables from row word line and
// column strobe, row read through the read word lines.
module sqm_cell_array #(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_commit,
  input  logic [(1<<ROW_BITS)-1:0]   wr_wl,
  input  logic [(1<<COL_BITS)-1:0]   wr_col,
  input  logic                       wr_bit,
  input  logic [(1<<ROW_BITS)-1:0]   rd_wl,
  output logic [(1<<COL_BITS)-1:0]   rd_row
);

  localparam int ROWS = 1 << ROW_BITS;
  localparam int COLS = 1 << COL_BITS;

  logic [ROWS-1:0][COLS-1:0] row_q;
  logic [ROWS-1:0][COLS-1:0] row_d;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_cell
      logic cell_we;
      assign cell_we     = wr_commit & wr_wl[r] & wr_col[c];
      assign row_d[r][c] = cell_we ? wr_bit : row_q[r][c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else begin
      row_q <= row_d;
    end
  end

  always_comb begin
    rd_row = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (rd_wl[r]) rd_row = rd_row | row_q[r];
    end
  end

endmodule

// File: rtl/sqm_col_mux.sv
// Column multiplexer: one bit out of the selected row.
module sqm_col_mux #(
  parameter int COL_BITS = 2
) (
  input  logic [(1<<COL_BITS)-1:0] row_bits,
  input  logic [COL_BITS-1:0]      col_idx,
  output logic                     bit_out
);

  assign bit_out = row_bits[col_idx];

endmodule

// File: rtl/sqarr_bitmem.sv
module sqarr_bitmem #(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         chip_sel,
  input  logic                         out_en,
  input  logic                         wr_en,
  input  logic [ROW_BITS+COL_BITS-1:0] addr,
  input  logic                         din,
  output logic                         dout,
  output logic                         dout_oe
);

  import sqm_pkg::*;

  localparam int ADDR_W = ROW_BITS + COL_BITS;
  localparam int ROWS   = 1 << ROW_BITS;
  localparam int COLS   = 1 << COL_BITS;

  sqm_acc_e          acc_kind;
  logic              wr_strobe;
  logic              commit;
  logic [ADDR_W-1:0] commit_addr;
  logic              commit_bit;
  logic [ROWS-1:0]   rd_wl;
  logic [ROWS-1:0]   wr_wl;
  logic [COLS-1:0]   wr_col;
  logic [COLS-1:0]   rd_row;
  logic              arr_bit;
  logic              fwd_hit;
  logic              rd_bit;
  logic              oe_d, oe_q;
  logic              dout_d, dout_q;

  // Cycle classification: deselect masks everything, write beats read.
  always_comb begin
    acc_kind = ACC_IDLE;
    if (chip_sel) begin
      if (wr_en)       acc_kind = ACC_WRITE;
      else if (out_en) acc_kind = ACC_READ;
    end
  end

  assign wr_strobe = (acc_kind == ACC_WRITE);

  sqm_write_ctrl #(.ADDR_W(ADDR_W)) u_wr_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (wr_strobe),
    .addr        (addr),
    .din         (din),
    .commit      (commit),
    .commit_addr (commit_addr),
    .commit_bit  (commit_bit)
  );

  sqm_onehot_decoder #(.SEL_BITS(ROW_BITS)) u_rd_row_dec (
    .sel_idx   (addr[ADDR_W-1:COL_BITS]),
    .sel_lines (rd_wl)
  );

  sqm_onehot_decoder #(.SEL_BITS(ROW_BITS)) u_wr_row_dec (
    .sel_idx   (commit_addr[ADDR_W-1:COL_BITS]),
    .sel_lines (wr_wl)
  );

  sqm_onehot_decoder #(.SEL_BITS(COL_BITS)) u_wr_col_dec (
    .sel_idx   (commit_addr[COL_BITS-1:0]),
    .sel_lines (wr_col)
  );

  sqm_cell_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_commit (commit),
    .wr_wl     (wr_wl),
    .wr_col    (wr_col),
    .wr_bit    (commit_bit),
    .rd_wl     (rd_wl),
    .rd_row    (rd_row)
  );

  sqm_col_mux #(.COL_BITS(COL_BITS)) u_col_mux (
    .row_bits (rd_row),
    .col_idx  (addr[COL_BITS-1:0]),
    .bit_out  (arr_bit)
  );

  // A commit landing on the edge that samples the read is forwarded (R8).
  assign fwd_hit = commit & (commit_addr == addr);
  assign rd_bit  = fwd_hit ? commit_bit : arr_bit;

  always_comb begin
    oe_d   = (acc_kind == ACC_READ);
    dout_d = oe_d & rd_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      dout_q <= 1'b0;
    end else begin
      oe_q   <= oe_d;
      dout_q <= dout_d;
    end
  end

  assign dout_oe = oe_q;
  assign dout    = dout_q;

endmodule

// File: rtl/sqarr_bitmem_chk.sv
module sqarr_bitmem_chk (
  input logic clk,
  input logic rst_n,
  input logic chip_sel,
  input logic out_en,
  input logic wr_en,
  input logic dout,
  input logic dout_oe
);

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel && out_en && !wr_en) |=> dout_oe);

  assert_no_read_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(chip_sel && out_en && !wr_en) |=> !dout_oe);

  assert_undriven_is_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> (dout == 1'b0));

  assert_deselect_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_sel |=> !dout_oe);

  assert_write_beats_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel && wr_en) |=> !dout_oe);

endmodule

bind sqarr_bitmem sqarr_bitmem_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chip_sel (chip_sel),
  .out_en   (out_en),
  .wr_en    (wr_en),
  .dout     (dout),
  .dout_oe  (dout_oe)
);

// File: tb/test_sqarr_bitmem.sv
`timescale 1ns/1ps
module test_sqarr_bitmem;

  logic       clk;
  logic       rst_n;
  logic       chip_sel;
  logic       out_en;
  logic       wr_en;
  logic [3:0] addr;
  logic       din;
  logic       dout;
  logic       dout_oe;

  int checks;
  int failures;
  bit done;

  // Behavioural reference state
  bit       ref_mem [16];
  bit       ref_pend;
  int       ref_paddr;
  bit       ref_pbit;

  sqarr_bitmem i_sqarr_bitmem (
    .clk      (clk),
    .rst_n    (rst_n),
    .chip_sel (chip_sel),
    .out_en   (out_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .din      (din),
    .dout     (dout),
    .dout_oe  (dout_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string tag, bit act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // One clock: drive inputs, step the reference model, compare after edge.
  task automatic cyc(bit cs, bit oe, bit we, int a, bit d, string tag);
    bit exp_oe;
    bit exp_do;
    bit strobe;
    chip_sel = cs; out_en = oe; wr_en = we; addr = 4'(a); din = d;
    @(posedge clk);
    strobe = cs && we;
    if (ref_pend && !strobe) ref_mem[ref_paddr] = ref_pbit;
    exp_oe = cs && oe && !we;
    exp_do = exp_oe ? ref_mem[a] : 1'b0;
    if (strobe) begin
      ref_pend = 1'b1; ref_paddr = a; ref_pbit = d;
    end else begin
      ref_pend = 1'b0;
    end
    @(negedge clk);
    check(tag, dout_oe, exp_oe, "dout_oe");
    check(tag, dout, exp_do, "dout");
  endtask

  task automatic wr1(int a, bit d, string tag);
    cyc(1, 0, 1, a, d, tag);
    cyc(0, 0, 0, 0, 0, tag);
  endtask

  task automatic read_range(int lo, int hi, string tag);
    for (int a = lo; a <= hi; a++) cyc(1, 1, 0, a, 0, tag);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit [7:0] lfsr;
    checks = 0; failures = 0; done = 1'b0;
    for (int i = 0; i < 16; i++) ref_mem[i] = 1'b0;
    ref_pend = 1'b0; ref_paddr = 0; ref_pbit = 1'b0;
    chip_sel = 0; out_en = 0; wr_en = 0; addr = 0; din = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", dout_oe, 1'b0, "dout_oe in reset");
    check("R1", dout, 1'b0, "dout in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", dout_oe, 1'b0, "dout_oe after reset");
    read_range(0, 15, "R1");

    // Single write then full readback
    wr1(5, 1, "R5");
    read_range(0, 15, "R7");

    // Multi-cycle strobe: only the last cycle's address/data are stored
    cyc(1, 0, 1, 9, 1, "R5");
    cyc(1, 0, 1, 10, 0, "R5");
    cyc(1, 0, 1, 10, 1, "R5");
    cyc(0, 0, 0, 0, 0, "R5");
    read_range(8, 11, "R5");

    // Row neighbours: set 4,6,7, clear 5
    wr1(4, 1, "R7"); wr1(6, 1, "R7"); wr1(7, 1, "R7"); wr1(5, 0, "R7");
    read_range(4, 7, "R7");
    wr1(6, 0, "R7");
    read_range(0, 15, "R7");

    // Deselected: nothing happens
    cyc(0, 0, 1, 0, 1, "R4");
    cyc(0, 0, 1, 0, 1, "R4");
    cyc(0, 1, 0, 0, 0, "R4");
    cyc(0, 1, 1, 15, 1, "R4");
    cyc(0, 0, 0, 0, 0, "R4");
    read_range(0, 0, "R4");
    read_range(15, 15, "R4");

    // Write and output enable together
    cyc(1, 1, 1, 12, 1, "R6");
    cyc(1, 1, 1, 12, 1, "R6");
    cyc(1, 1, 0, 12, 0, "R6");
    read_range(12, 12, "R6");

    // Commit and read on the same edge
    cyc(1, 0, 1, 3, 1, "R8");
    cyc(1, 1, 0, 3, 0, "R8");
    cyc(1, 0, 1, 3, 0, "R8");
    cyc(1, 1, 0, 12, 0, "R8");
    read_range(3, 3, "R8");

    // Strobe ended by dropping chip select while wr_en stays high
    cyc(1, 0, 1, 14, 1, "R5");
    cyc(0, 0, 1, 14, 0, "R5");
    read_range(14, 14, "R5");

    // Selected idle cycles keep output off
    cyc(1, 0, 0, 14, 0, "R3");
    cyc(1, 0, 0, 3, 1, "R3");

    // Pseudo-random traffic
    lfsr = 8'h5A;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cyc(lfsr[7] | lfsr[6], lfsr[5], lfsr[4] & lfsr[2], int'(lfsr[3:0]),
          lfsr[1], "R2");
    end
    read_range(0, 15, "R2");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule